// File: doc/BRIEF.md
# Dual-Port Synchronous RAM with Collision Flag

This block is a true dual-port memory. Two ports, each with its own clock, can read or write any word at any time, including the same word. Each word holds 18 bits split into two 9-bit lanes, and every access names the lanes it touches. A port takes part in a cycle only when both of its chip enables are active. Its read path can be flow-through, with data one cycle after the address edge, or pipelined, with one more register stage. An active-low output enable gates the read data at once, without waiting for a clock.

The storage is built as one bank per port. Each bank is written only by its own port's clock, so no storage element has two writers. A word's value is the XOR of all banks at that address. A write stores the new data XORed with the other banks, so the combined value becomes the written data.

A separate compare stage runs on its own clock. It watches both ports and raises a one-cycle collision flag on a port when the other port wrote the address that this port accessed in the same cycle. When both ports write the same word, both flags rise and the stored word is undefined.

Top module: `dual_port_ram_cf`

## Requirements
- R1: A synchronous reset clears the read stages, the collision flags and every memory word. After reset both ports drive no lanes, and a read of any word returns zero.
- R2: A port is selected only when its `ce_n` is 0 and its `ce` is 1. A port that is not selected neither writes nor reads, and its flow-through output drives no lanes after that edge.
- R3: A selected write commits at the clock edge. Lane 0 is bits 8:0 and is written only when `be[0]` is 1. Lane 1 is bits 17:9 and is written only when `be[1]` is 1. A lane whose enable is 0 keeps its old content.
- R4: A selected read drives exactly the lanes whose `be` bits were 1 at the address edge (`rdrv` mirrors them). Lanes that are not driven read as zero on `rdata`.
- R5: With `pipe` = 0 (flow-through), read data and lane drive appear right after the edge that captured the read.
- R6: With `pipe` = 1 (pipelined), read data and lane drive appear one clock edge later than in flow-through mode.
- R7: In pipelined mode, a deselect or a write takes effect on the outputs two edges later. The lanes of a previous read stay driven for one more cycle after the deselecting edge.
- R8: `oe_n` = 1 forces `rdrv` to 0 and `rdata` to 0 at once, with no clock edge. Returning `oe_n` to 0 restores the held read result.
- R9: After a compare-clock edge where both ports are selected at the same address and the other port writes, a port's `col` is 1 for one cycle. A double write raises `col` on both ports. A read/read pair, different addresses or an unselected port raise nothing.
- R10: Each port can read and write any address, from 0 to DEPTH-1. A word written by one port is read back by the other port at any later edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Clock of port A |
| clk_b | input | 1 | Clock of port B |
| clk_cmp | input | 1 | Clock of the collision compare |
| rst | input | 1 | Synchronous active-high reset, applied in every domain |
| a_ce_n | input | 1 | Port A chip enable, active low |
| a_ce | input | 1 | Port A chip enable, active high |
| a_we | input | 1 | Port A write (1) or read (0) |
| a_be | input | 2 | Port A lane enables, bit 0 for bits 8:0 |
| a_addr | input | AW | Port A word address |
| a_wdata | input | 18 | Port A write data |
| a_pipe | input | 1 | Port A read mode, 1 selects pipelined |
| a_oe_n | input | 1 | Port A output enable, active low, combinational |
| a_rdata | output | 18 | Port A read data, zero in undriven lanes |
| a_rdrv | output | 2 | Port A lanes being driven |
| a_col | output | 1 | Port A collision flag |
| b_ce_n | input | 1 | Port B chip enable, active low |
| b_ce | input | 1 | Port B chip enable, active high |
| b_we | input | 1 | Port B write (1) or read (0) |
| b_be | input | 2 | Port B lane enables, bit 0 for bits 8:0 |
| b_addr | input | AW | Port B word address |
| b_wdata | input | 18 | Port B write data |
| b_pipe | input | 1 | Port B read mode, 1 selects pipelined |
| b_oe_n | input | 1 | Port B output enable, active low, combinational |
| b_rdata | output | 18 | Port B read data, zero in undriven lanes |
| b_rdrv | output | 2 | Port B lanes being driven |
| b_col | output | 1 | Port B collision flag |

## Verification
Flow-through read data and the collision flag are due right after the edge that captured the access. Pipelined data is due one edge later, and so is the end of driving after a deselect. The output enable acts with no edge at all.

The bench drives inputs just after a falling edge and updates its behavioural model on the rising edge. It compares both ports one nanosecond after the next falling edge, so every result that is due after an edge has settled. The output-enable checks are made within a single low phase, before any edge arrives, so a registered gate would be caught.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

    localparam int DW = 18;
    localparam int LW = 9;
    localparam int NL = DW / LW;
    localparam int NP = 2;

    typedef logic [NL-1:0] lane_t;
    typedef logic [DW-1:0] word_t;

    typedef enum logic {
        RD_FLOW = 1'b0,
        RD_PIPE = 1'b1
    } rdmode_t;

    typedef struct packed {
        lane_t drv;
        word_t data;
    } rd_stage_t;

    function automatic word_t lane_mask(input lane_t en);
        word_t m;
        for (int l = 0; l < NL; l++) begin
            m[l*LW +: LW] = {LW{en[l]}};
        end
        return m;
    endfunction

endpackage

// File: rtl/dpr_bank.sv
module dpr_bank
    import dpr_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int AW    = 10
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  lane_t                 wr_be,
    input  logic [AW-1:0]         wr_addr,
    input  word_t                 wr_word,
    input  logic [NP-1:0][AW-1:0] rd_addr,
    output logic [NP-1:0][DW-1:0] rd_word
);

    word_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_en) begin
            for (int l = 0; l < NL; l++) begin
                if (wr_be[l]) begin
                    mem[wr_addr][l*LW +: LW] <= wr_word[l*LW +: LW];
                end
            end
        end
    end

    always_comb begin
        for (int j = 0; j < NP; j++) begin
            rd_word[j] = mem[rd_addr[j]];
        end
    end

endmodule

// File: rtl/dpr_port.sv
module dpr_port
    import dpr_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ce_n,
    input  logic          ce,
    input  logic          we,
    input  lane_t         be,
    input  logic [AW-1:0] addr,
    input  word_t         wdata,
    input  logic          pipe,
    input  logic          oe_n,
    input  word_t         other_word,
    input  word_t         merged_word,
    output logic          acc_sel,
    output logic          bank_we,
    output lane_t         bank_be,
    output logic [AW-1:0] bank_addr,
    output word_t         bank_word,
    output word_t         rdata,
    output lane_t         rdrv
);

    rd_stage_t stg_flow, stg_pipe, stg_out;
    rdmode_t   mode;

    assign acc_sel   = !ce_n && ce;
    assign bank_we   = acc_sel && we;
    assign bank_be   = be;
    assign bank_addr = addr;
    assign bank_word = wdata ^ other_word;
    assign mode      = rdmode_t'(pipe);

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_flow <= '0;
            stg_pipe <= '0;
        end else begin
            stg_pipe <= stg_flow;
            if (acc_sel && !we) begin
                stg_flow.drv  <= be;
                stg_flow.data <= merged_word & lane_mask(be);
            end else begin
                stg_flow <= '0;
            end
        end
    end

    always_comb begin
        stg_out = (mode == RD_PIPE) ? stg_pipe : stg_flow;
        rdrv    = oe_n ? '0 : stg_out.drv;
        rdata   = stg_out.data & lane_mask(rdrv);
    end

endmodule

// File: rtl/dpr_collide.sv
module dpr_collide
    import dpr_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NP-1:0]         sel,
    input  logic [NP-1:0]         we,
    input  logic [NP-1:0][AW-1:0] addr,
    output logic [NP-1:0]         col
);

    logic [NP-1:0] hit;

    always_comb begin
        hit = '0;
        for (int p = 0; p < NP; p++) begin
            for (int q = 0; q < NP; q++) begin
                if (q != p && sel[p] && sel[q] && we[q] && addr[p] == addr[q]) begin
                    hit[p] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            col <= '0;
        end else begin
            col <= hit;
        end
    end

endmodule

// File: rtl/dual_port_ram_cf.sv
module dual_port_ram_cf
    import dpr_pkg::*;
#(
    parameter  int DEPTH = 1024,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk_a,
    input  logic          clk_b,
    input  logic          clk_cmp,
    input  logic          rst,
    input  logic          a_ce_n,
    input  logic          a_ce,
    input  logic          a_we,
    input  logic [1:0]    a_be,
    input  logic [AW-1:0] a_addr,
    input  logic [17:0]   a_wdata,
    input  logic          a_pipe,
    input  logic          a_oe_n,
    output logic [17:0]   a_rdata,
    output logic [1:0]    a_rdrv,
    output logic          a_col,
    input  logic          b_ce_n,
    input  logic          b_ce,
    input  logic          b_we,
    input  logic [1:0]    b_be,
    input  logic [AW-1:0] b_addr,
    input  logic [17:0]   b_wdata,
    input  logic          b_pipe,
    input  logic          b_oe_n,
    output logic [17:0]   b_rdata,
    output logic [1:0]    b_rdrv,
    output logic          b_col
);

    logic [NP-1:0]                 clk_v;
    logic [NP-1:0][AW-1:0]         port_addr;
    logic [NP-1:0][NP-1:0][DW-1:0] bank_rd;
    logic [NP-1:0][DW-1:0]         merged;
    logic [NP-1:0][DW-1:0]         others;
    logic [NP-1:0]                 bk_we;
    logic [NP-1:0][NL-1:0]         bk_be;
    logic [NP-1:0][AW-1:0]         bk_addr;
    logic [NP-1:0][DW-1:0]         bk_word;
    logic [NP-1:0]                 p_sel;
    logic [NP-1:0]                 col_v;

    assign clk_v     = {clk_b, clk_a};
    assign port_addr = {b_addr, a_addr};

    generate
        for (genvar k = 0; k < NP; k++) begin : g_bank
            dpr_bank #(.DEPTH(DEPTH), .AW(AW)) u_bank (
                .clk     (clk_v[k]),
                .rst     (rst),
                .wr_en   (bk_we[k]),
                .wr_be   (bk_be[k]),
                .wr_addr (bk_addr[k]),
                .wr_word (bk_word[k]),
                .rd_addr (port_addr),
                .rd_word (bank_rd[k])
            );
        end
    endgenerate

    always_comb begin
        for (int p = 0; p < NP; p++) begin
            merged[p] = '0;
            for (int k = 0; k < NP; k++) begin
                merged[p] = merged[p] ^ bank_rd[k][p];
            end
            others[p] = merged[p] ^ bank_rd[p][p];
        end
    end

    dpr_port #(.AW(AW)) u_port_a (
        .clk         (clk_a),
        .rst         (rst),
        .ce_n        (a_ce_n),
        .ce          (a_ce),
        .we          (a_we),
        .be          (a_be),
        .addr        (a_addr),
        .wdata       (a_wdata),
        .pipe        (a_pipe),
        .oe_n        (a_oe_n),
        .other_word  (others[0]),
        .merged_word (merged[0]),
        .acc_sel     (p_sel[0]),
        .bank_we     (bk_we[0]),
        .bank_be     (bk_be[0]),
        .bank_addr   (bk_addr[0]),
        .bank_word   (bk_word[0]),
        .rdata       (a_rdata),
        .rdrv        (a_rdrv)
    );

    dpr_port #(.AW(AW)) u_port_b (
        .clk         (clk_b),
        .rst         (rst),
        .ce_n        (b_ce_n),
        .ce          (b_ce),
        .we          (b_we),
        .be          (b_be),
        .addr        (b_addr),
        .wdata       (b_wdata),
        .pipe        (b_pipe),
        .oe_n        (b_oe_n),
        .other_word  (others[1]),
        .merged_word (merged[1]),
        .acc_sel     (p_sel[1]),
        .bank_we     (bk_we[1]),
        .bank_be     (bk_be[1]),
        .bank_addr   (bk_addr[1]),
        .bank_word   (bk_word[1]),
        .rdata       (b_rdata),
        .rdrv        (b_rdrv)
    );

    dpr_collide #(.AW(AW)) u_collide (
        .clk  (clk_cmp),
        .rst  (rst),
        .sel  (p_sel),
        .we   ({b_we, a_we}),
        .addr (port_addr),
        .col  (col_v)
    );

    assign a_col = col_v[0];
    assign b_col = col_v[1];

endmodule

// File: rtl/dpr_checker.sv
module dpr_checker #(
    parameter int AW = 10
) (
    input logic          clk_a,
    input logic          clk_b,
    input logic          clk_cmp,
    input logic          rst,
    input logic          a_ce_n,
    input logic          a_ce,
    input logic          a_we,
    input logic [1:0]    a_be,
    input logic [AW-1:0] a_addr,
    input logic          a_pipe,
    input logic          a_oe_n,
    input logic [1:0]    a_rdrv,
    input logic          a_col,
    input logic          b_ce_n,
    input logic          b_ce,
    input logic          b_we,
    input logic [1:0]    b_be,
    input logic [AW-1:0] b_addr,
    input logic          b_pipe,
    input logic          b_oe_n,
    input logic [1:0]    b_rdrv,
    input logic          b_col
);

    logic [1:0] warm_a, warm_b;
    logic       a_rd, b_rd, a_wr, b_wr;

    assign a_rd = !a_ce_n && a_ce && !a_we;
    assign b_rd = !b_ce_n && b_ce && !b_we;
    assign a_wr = !a_ce_n && a_ce && a_we;
    assign b_wr = !b_ce_n && b_ce && b_we;

    always_ff @(posedge clk_a) begin
        if (rst) warm_a <= '0;
        else if (warm_a != 2'd3) warm_a <= warm_a + 2'd1;
    end

    always_ff @(posedge clk_b) begin
        if (rst) warm_b <= '0;
        else if (warm_b != 2'd3) warm_b <= warm_b + 2'd1;
    end

    AST_OE_GATES_A: assert property (@(posedge clk_a) disable iff (rst) a_oe_n |-> a_rdrv == 2'b00); // R8
    AST_OE_GATES_B: assert property (@(posedge clk_b) disable iff (rst) b_oe_n |-> b_rdrv == 2'b00); // R8

    AST_FLOW_LANES_A: assert property (@(posedge clk_a) disable iff (rst)
        (warm_a >= 2'd1 && !a_pipe && !a_oe_n) |-> a_rdrv == ($past(a_rd) ? $past(a_be) : 2'b00)); // R5
    AST_FLOW_LANES_B: assert property (@(posedge clk_b) disable iff (rst)
        (warm_b >= 2'd1 && !b_pipe && !b_oe_n) |-> b_rdrv == ($past(b_rd) ? $past(b_be) : 2'b00)); // R4

    AST_PIPE_LANES_A: assert property (@(posedge clk_a) disable iff (rst)
        (warm_a >= 2'd2 && a_pipe && !a_oe_n) |-> a_rdrv == ($past(a_rd, 2) ? $past(a_be, 2) : 2'b00)); // R6
    AST_PIPE_HOLD_B: assert property (@(posedge clk_b) disable iff (rst)
        (warm_b >= 2'd2 && b_pipe && !b_oe_n && !$past(b_rd) && $past(b_rd, 2) && $past(b_be, 2) != 2'b00)
        |-> b_rdrv != 2'b00); // R7

    AST_COL_CAUSE_A: assert property (@(posedge clk_cmp) disable iff (rst)
        a_col |-> $past(b_wr && (a_rd || a_wr) && a_addr == b_addr)); // R9
    AST_COL_CAUSE_B: assert property (@(posedge clk_cmp) disable iff (rst)
        b_col |-> $past(a_wr && (b_rd || b_wr) && a_addr == b_addr)); // R9

endmodule

bind dual_port_ram_cf dpr_checker #(.AW(AW)) i_dpr_checker (
    .clk_a   (clk_a),
    .clk_b   (clk_b),
    .clk_cmp (clk_cmp),
    .rst     (rst),
    .a_ce_n  (a_ce_n),
    .a_ce    (a_ce),
    .a_we    (a_we),
    .a_be    (a_be),
    .a_addr  (a_addr),
    .a_pipe  (a_pipe),
    .a_oe_n  (a_oe_n),
    .a_rdrv  (a_rdrv),
    .a_col   (a_col),
    .b_ce_n  (b_ce_n),
    .b_ce    (b_ce),
    .b_we    (b_we),
    .b_be    (b_be),
    .b_addr  (b_addr),
    .b_pipe  (b_pipe),
    .b_oe_n  (b_oe_n),
    .b_rdrv  (b_rdrv),
    .b_col   (b_col)
);

// File: tb/test_dual_port_ram_cf.sv
module test_dual_port_ram_cf;

    localparam int DEPTH = 1024;
    localparam int AW    = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic          ce_n [2];
    logic          ce   [2];
    logic          we   [2];
    logic          pipe [2];
    logic          oe_n [2];
    logic [1:0]    be   [2];
    logic [AW-1:0] addr [2];
    logic [17:0]   wdat [2];
    logic [17:0]   rdata[2];
    logic [1:0]    rdrv [2];
    logic          col  [2];

    int    checks = 0;
    int    fails  = 0;
    string tag    = "R1";

    dual_port_ram_cf #(.DEPTH(DEPTH)) i_dual_port_ram_cf (
        .clk_a(clk), .clk_b(clk), .clk_cmp(clk), .rst(rst),
        .a_ce_n(ce_n[0]), .a_ce(ce[0]), .a_we(we[0]), .a_be(be[0]), .a_addr(addr[0]),
        .a_wdata(wdat[0]), .a_pipe(pipe[0]), .a_oe_n(oe_n[0]),
        .a_rdata(rdata[0]), .a_rdrv(rdrv[0]), .a_col(col[0]),
        .b_ce_n(ce_n[1]), .b_ce(ce[1]), .b_we(we[1]), .b_be(be[1]), .b_addr(addr[1]),
        .b_wdata(wdat[1]), .b_pipe(pipe[1]), .b_oe_n(oe_n[1]),
        .b_rdata(rdata[1]), .b_rdrv(rdrv[1]), .b_col(col[1])
    );

    // behavioural reference model
    logic [17:0] mdl_mem [DEPTH];
    logic [1:0]  f_drv [2];
    logic [1:0]  p_drv [2];
    logic [17:0] f_dat [2];
    logic [17:0] p_dat [2];
    logic        e_col [2];
    logic        msel  [2];

    function automatic logic [17:0] lmask(input logic [1:0] b);
        return {{9{b[1]}}, {9{b[0]}}};
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mdl_mem[i] = '0;
            for (int p = 0; p < 2; p++) begin
                f_drv[p] = '0; p_drv[p] = '0; f_dat[p] = '0; p_dat[p] = '0; e_col[p] = 1'b0;
            end
        end else begin
            for (int p = 0; p < 2; p++) msel[p] = !ce_n[p] && ce[p];
            e_col[0] = msel[0] && msel[1] && addr[0] == addr[1] && we[1];
            e_col[1] = msel[0] && msel[1] && addr[0] == addr[1] && we[0];
            for (int p = 0; p < 2; p++) begin
                p_drv[p] = f_drv[p];
                p_dat[p] = f_dat[p];
                if (msel[p] && !we[p]) begin
                    f_drv[p] = be[p];
                    f_dat[p] = mdl_mem[addr[p]] & lmask(be[p]);
                end else begin
                    f_drv[p] = '0;
                    f_dat[p] = '0;
                end
            end
            for (int p = 0; p < 2; p++) begin
                if (msel[p] && we[p]) begin
                    for (int l = 0; l < 2; l++) begin
                        if (be[p][l]) mdl_mem[addr[p]][l*9 +: 9] = wdat[p][l*9 +: 9];
                    end
                end
            end
        end
    end

    task automatic compare();
        for (int p = 0; p < 2; p++) begin
            logic [1:0]  ed;
            logic [17:0] ev;
            ed = oe_n[p] ? 2'b00 : (pipe[p] ? p_drv[p] : f_drv[p]);
            ev = (pipe[p] ? p_dat[p] : f_dat[p]) & lmask(ed);
            checks++;
            if (rdrv[p] !== ed || rdata[p] !== ev || col[p] !== e_col[p]) begin
                fails++;
                $display("FAIL %s port %0d: actual drv=%b data=%h col=%b expected drv=%b data=%h col=%b",
                         tag, p, rdrv[p], rdata[p], col[p], ed, ev, e_col[p]);
            end
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        #1;
        compare();
    endtask

    task automatic idle(input int p);
        ce_n[p] = 1'b1; ce[p] = 1'b0; we[p] = 1'b0; be[p] = 2'b00;
    endtask

    task automatic acc(input int p, input logic w, input logic [1:0] b,
                       input logic [AW-1:0] a, input logic [17:0] d);
        ce_n[p] = 1'b0; ce[p] = 1'b1; we[p] = w; be[p] = b; addr[p] = a; wdat[p] = d;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog (all requirements): actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        for (int p = 0; p < 2; p++) begin
            idle(p); pipe[p] = 1'b0; oe_n[p] = 1'b0; addr[p] = '0; wdat[p] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state and cleared memory
        tag = "R1";
        step();
        acc(0, 1'b0, 2'b11, 10'd7, '0);
        acc(1, 1'b0, 2'b11, 10'd900, '0);
        step();

        // R5 / R3: write then flow-through read
        tag = "R5";
        acc(0, 1'b1, 2'b11, 10'd10, 18'h2A5A5); idle(1);
        step();
        acc(0, 1'b0, 2'b11, 10'd10, '0);
        step();
        tag = "R3";
        acc(0, 1'b1, 2'b01, 10'd10, 18'h3FFFF);
        step();
        acc(0, 1'b0, 2'b11, 10'd10, '0);
        step();
        acc(0, 1'b1, 2'b10, 10'd10, 18'h00000);
        step();
        acc(0, 1'b0, 2'b11, 10'd10, '0);
        step();

        // R4: lane-qualified read
        tag = "R4";
        acc(0, 1'b1, 2'b11, 10'd11, 18'h1C3E7);
        step();
        acc(0, 1'b0, 2'b10, 10'd11, '0);
        step();
        acc(0, 1'b0, 2'b01, 10'd11, '0);
        step();

        // R6: pipelined reads on both ports
        tag = "R6";
        pipe[0] = 1'b1; pipe[1] = 1'b1;
        acc(0, 1'b0, 2'b11, 10'd10, '0); acc(1, 1'b0, 2'b11, 10'd11, '0);
        step();
        acc(0, 1'b0, 2'b11, 10'd11, '0); acc(1, 1'b0, 2'b01, 10'd10, '0);
        step();

        // R7: deselect keeps the pipelined output one extra cycle
        tag = "R7";
        idle(0); idle(1);
        step();
        step();
        acc(0, 1'b0, 2'b11, 10'd11, '0);
        step();
        acc(0, 1'b1, 2'b11, 10'd12, 18'h12345);
        step();
        idle(0);
        step();
        pipe[0] = 1'b0; pipe[1] = 1'b0;

        // R2: partial chip enables block access
        tag = "R2";
        acc(0, 1'b1, 2'b11, 10'd10, 18'h00001); ce[0] = 1'b0;
        step();
        acc(0, 1'b1, 2'b11, 10'd10, 18'h00002); ce_n[0] = 1'b1;
        step();
        acc(0, 1'b0, 2'b11, 10'd10, '0); ce_n[0] = 1'b1; ce[0] = 1'b1;
        step();
        acc(0, 1'b0, 2'b11, 10'd10, '0);
        step();

        // R8: output enable is combinational
        tag = "R8";
        oe_n[0] = 1'b1;
        #1 compare();
        oe_n[0] = 1'b0;
        #1 compare();
        idle(0);
        step();

        // R10: cross-port visibility and top address
        tag = "R10";
        acc(0, 1'b1, 2'b11, 10'(DEPTH - 1), 18'h2F0F0);
        step();
        idle(0); acc(1, 1'b0, 2'b11, 10'(DEPTH - 1), '0);
        step();
        acc(1, 1'b1, 2'b11, 10'd0, 18'h15555); idle(0);
        step();
        acc(0, 1'b0, 2'b11, 10'd0, '0); idle(1);
        step();

        // R9: collision flag cases
        tag = "R9";
        acc(0, 1'b0, 2'b11, 10'd20, '0); acc(1, 1'b1, 2'b11, 10'd20, 18'h0ABCD);
        step();
        acc(0, 1'b1, 2'b11, 10'd21, 18'h11111); acc(1, 1'b1, 2'b11, 10'd21, 18'h22222);
        step();
        acc(0, 1'b0, 2'b11, 10'd22, '0); acc(1, 1'b0, 2'b11, 10'd22, '0);
        step();
        acc(0, 1'b1, 2'b11, 10'd23, 18'h00003); acc(1, 1'b0, 2'b11, 10'd24, '0);
        step();
        acc(0, 1'b0, 2'b11, 10'd25, '0); acc(1, 1'b1, 2'b11, 10'd25, 18'h00004); ce[1] = 1'b0;
        step();
        acc(0, 1'b1, 2'b11, 10'd26, 18'h00005); acc(1, 1'b0, 2'b11, 10'd26, '0);
        step();
        idle(0); idle(1);
        step();

        // R10: mixed traffic on both ports
        tag = "R10";
        for (int n = 0; n < 400; n++) begin
            for (int p = 0; p < 2; p++) begin
                if ($urandom_range(0, 4) == 0) idle(p);
                else acc(p, 1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
                         10'($urandom_range(0, 15)), 18'($urandom));
                pipe[p] = 1'($urandom_range(0, 1));
                oe_n[p] = ($urandom_range(0, 7) == 0);
            end
            if (we[0] && we[1] && addr[0] == addr[1]) we[1] = 1'b0;
            step();
        end

        summary();
        $finish;
    end

endmodule